// File: doc/BRIEF.md
# Two-Wire Device-Line Byte Transmitter

This block sends one byte from a host controller to an attached keyboard or mouse over an open-drain clock/data pair. When a byte is offered on the request port, the block first pulls the clock wire low for a request interval. Near the end of that interval it pulls the data wire low as the start bit. It then lets go of the clock so that the device can generate clock pulses.

Each falling edge of the device clock moves the next frame bit onto the data wire: eight data bits least significant first, an odd parity bit, and a released stop bit. On the falling edge after that, the block samples the device's acknowledge. It then holds the clock low for a closing interval and reports completion.

Both wires are read through a synchroniser. A watchdog ends a stalled transfer with an error. All intervals are given in microseconds and scaled by a clocks-per-microsecond parameter. Below, REQ = REQ_US×CLKS_PER_US, END = END_US×CLKS_PER_US and TO = TIMEOUT_US×CLKS_PER_US, all counted in system clock cycles.

Top module: `ps2_host_tx`

## Requirements
- R1: Out of reset, and whenever idle, `tx_ready` is 1, `ps2_clk_oe` and `ps2_dat_oe` are 0, and `done`/`err` are 0.
- R2: A request is taken on a rising clock edge with `tx_valid` and `tx_ready` both high. From the next cycle, `ps2_clk_oe` is 1 for exactly REQ+1 cycles, and `tx_ready` stays 0 until the cycle in which `done` is 1.
- R3: `ps2_dat_oe` is 0 during the first REQ cycles of the clock hold. It is 1 in the last cycle of the hold, and it is still 1 when `ps2_clk_oe` falls (start bit = 0).
- R4: After each synchronised falling edge of `ps2_clk_in`, the data wire carries the next data bit, least significant bit first. An output enable of 1 means the wire is driven low (bit 0).
- R5: The ninth bit sent is the odd parity bit: data bits plus parity hold an odd number of ones. The tenth bit is the stop bit, sent by releasing the wire (`ps2_dat_oe` = 0).
- R6: On the eleventh device falling edge, the block samples the data wire. If it is low, `err` is 0 when `done` fires; if it is high, `err` is 1 when `done` fires. `err` is never 1 without `done`.
- R7: After the eleventh falling edge, `ps2_clk_oe` is 1 for exactly END cycles with `ps2_dat_oe` at 0. `done` is 1 for one cycle, in the first cycle with the clock released.
- R8: In the data phase, if no device falling edge arrives for TO cycles (counted from clock release or from the previous edge), both enables drop, and `done` and `err` are 1 for one cycle with no closing hold.
- R9: `tx_valid` and `tx_data` are ignored while a transfer is in progress; the byte on the wire is the one accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_valid | input | 1 | Byte offered for sending |
| tx_data | input | 8 | Byte to send |
| tx_ready | output | 1 | Block idle, request will be taken |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | With `done`: missing acknowledge or timeout |
| ps2_clk_in | input | 1 | Clock wire level (asynchronous) |
| ps2_dat_in | input | 1 | Data wire level (asynchronous) |
| ps2_clk_oe | output | 1 | 1 pulls the clock wire low |
| ps2_dat_oe | output | 1 | 1 pulls the data wire low |

## Verification
The bench acts as the device and sends bytes of all zeros, all ones, and mixed patterns. These cover both parity values, so a shift in the wrong direction, a swapped parity sense or a stop bit that is not released is caught. The same frame is run with and without the acknowledge low, which separates the error-free end from the missing-acknowledge error. A transfer in which the device never clocks exercises the watchdog path and checks that it skips the closing hold. A second request offered while busy must leave the received byte unchanged. The lengths of both clock-hold intervals are measured to the exact cycle.

// File: rtl/ps2tx_pkg.sv
package ps2tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INHIBIT,
        ST_START,
        ST_SHIFT,
        ST_CLOSE
    } tx_state_e;

    // Bit 0 leaves first.
    typedef struct packed {
        logic       stop;
        logic       parity;
        logic [7:0] data;
        logic       start;
    } tx_frame_t;

    localparam int FRAME_BITS  = $bits(tx_frame_t);
    localparam int SHIFT_CNT_W = $clog2(FRAME_BITS);

    function automatic logic odd_parity(input logic [7:0] d);
        return ~(^d);
    endfunction

    function automatic tx_frame_t build_frame(input logic [7:0] d);
        tx_frame_t f;
        f.start  = 1'b0;
        f.data   = d;
        f.parity = odd_parity(d);
        f.stop   = 1'b1;
        return f;
    endfunction

endpackage

// File: rtl/ps2tx_sync.sv
module ps2tx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic clk_raw,
    input  logic dat_raw,
    output logic dat_s,
    output logic clk_fall
);
    logic [STAGES-1:0] c_q;
    logic [STAGES-1:0] d_q;
    logic              c_prev;

    generate
        if (STAGES < 2) begin : g_bad
            initial $error("ps2tx_sync needs at least two stages");
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            c_q    <= '1;
            d_q    <= '1;
            c_prev <= 1'b1;
        end else begin
            c_q    <= {c_q[STAGES-2:0], clk_raw};
            d_q    <= {d_q[STAGES-2:0], dat_raw};
            c_prev <= c_q[STAGES-1];
        end
    end

    assign dat_s    = d_q[STAGES-1];
    assign clk_fall = c_prev & ~c_q[STAGES-1];

endmodule

// File: rtl/ps2tx_timer.sv
module ps2tx_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/ps2tx_shifter.sv
module ps2tx_shifter
    import ps2tx_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   load,
    input  tx_frame_t              frame_in,
    input  logic                   shift,
    output logic                   out_bit,
    output logic [SHIFT_CNT_W-1:0] shift_cnt
);
    logic [FRAME_BITS-1:0]  sr_q;
    logic [SHIFT_CNT_W-1:0] cnt_q;
    logic                   past_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q    <= '1;
            cnt_q   <= '0;
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
            if (load) begin
                sr_q  <= frame_in;
                cnt_q <= '0;
            end else if (shift) begin
                sr_q  <= {1'b1, sr_q[FRAME_BITS-1:1]};
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign out_bit   = sr_q[0];
    assign shift_cnt = cnt_q;

    // R5: never more shifts than frame bits after the start bit
    p_shift_bound_r5: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= SHIFT_CNT_W'(FRAME_BITS - 1));

    // R5: once the stop bit is out, the line stays released until reload
    p_stop_released_r5: assert property (@(posedge clk) disable iff (rst)
        past_ok && !$past(load) && $past(cnt_q) == SHIFT_CNT_W'(FRAME_BITS - 1)
        |-> out_bit);

endmodule

// File: rtl/ps2_host_tx.sv
module ps2_host_tx
    import ps2tx_pkg::*;
#(
    parameter int CLKS_PER_US = 8,
    parameter int REQ_US      = 250,
    parameter int END_US      = 60,
    parameter int TIMEOUT_US  = 2000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tx_valid,
    input  logic [7:0] tx_data,
    output logic       tx_ready,
    output logic       done,
    output logic       err,
    input  logic       ps2_clk_in,
    input  logic       ps2_dat_in,
    output logic       ps2_clk_oe,
    output logic       ps2_dat_oe
);
    localparam int REQ_CYC = REQ_US * CLKS_PER_US;
    localparam int END_CYC = END_US * CLKS_PER_US;
    localparam int TO_CYC  = TIMEOUT_US * CLKS_PER_US;
    localparam int MAX_A   = (REQ_CYC > END_CYC) ? REQ_CYC : END_CYC;
    localparam int MAX_CYC = (MAX_A > TO_CYC) ? MAX_A : TO_CYC;
    localparam int TMR_W   = $clog2(MAX_CYC + 1);
    localparam logic [SHIFT_CNT_W-1:0] LAST_SHIFT = SHIFT_CNT_W'(FRAME_BITS - 1);

    tx_state_e              state_q, state_d;
    logic                   tmr_load;
    logic [TMR_W-1:0]       tmr_val;
    logic                   tmr_zero;
    logic                   sh_load, sh_shift, sh_bit;
    logic [SHIFT_CNT_W-1:0] sh_cnt;
    logic                   dat_s, clk_fall;
    logic                   nack_q, nack_d;
    logic                   done_q, done_d, err_q, err_d;
    logic                   past_ok;

    ps2tx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .clk_raw  (ps2_clk_in),
        .dat_raw  (ps2_dat_in),
        .dat_s    (dat_s),
        .clk_fall (clk_fall)
    );

    ps2tx_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_zero)
    );

    ps2tx_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (sh_load),
        .frame_in  (build_frame(tx_data)),
        .shift     (sh_shift),
        .out_bit   (sh_bit),
        .shift_cnt (sh_cnt)
    );

    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        nack_d   = nack_q;
        done_d   = 1'b0;
        err_d    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (tx_valid) begin
                    state_d  = ST_INHIBIT;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(REQ_CYC - 1);
                    sh_load  = 1'b1;
                    nack_d   = 1'b0;
                end
            end
            ST_INHIBIT: begin
                if (tmr_zero) state_d = ST_START;
            end
            ST_START: begin
                state_d  = ST_SHIFT;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(TO_CYC - 1);
            end
            ST_SHIFT: begin
                if (clk_fall) begin
                    tmr_load = 1'b1;
                    if (sh_cnt == LAST_SHIFT) begin
                        state_d = ST_CLOSE;
                        tmr_val = TMR_W'(END_CYC - 1);
                        nack_d  = dat_s;
                    end else begin
                        sh_shift = 1'b1;
                        tmr_val  = TMR_W'(TO_CYC - 1);
                    end
                end else if (tmr_zero) begin
                    state_d = ST_IDLE;
                    done_d  = 1'b1;
                    err_d   = 1'b1;
                end
            end
            ST_CLOSE: begin
                if (tmr_zero) begin
                    state_d = ST_IDLE;
                    done_d  = 1'b1;
                    err_d   = nack_q;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            nack_q  <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            past_ok <= 1'b0;
        end else begin
            state_q <= state_d;
            nack_q  <= nack_d;
            done_q  <= done_d;
            err_q   <= err_d;
            past_ok <= 1'b1;
        end
    end

    assign tx_ready   = (state_q == ST_IDLE);
    assign ps2_clk_oe = (state_q == ST_INHIBIT) || (state_q == ST_START) || (state_q == ST_CLOSE);
    assign ps2_dat_oe = ((state_q == ST_START) || (state_q == ST_SHIFT)) && !sh_bit;
    assign done       = done_q;
    assign err        = err_q;

    // R1: an idle block leaves both wires alone
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        tx_ready |-> !ps2_clk_oe && !ps2_dat_oe);

    // R6: an error is only reported together with completion
    p_err_with_done_r6: assert property (@(posedge clk) disable iff (rst)
        err |-> done);

    // R3: releasing clock into the data phase happens with the start bit already low
    p_start_held_r3: assert property (@(posedge clk) disable iff (rst)
        past_ok && $fell(ps2_clk_oe) && !done |-> ps2_dat_oe);

    // R4: during the data phase the wire only moves after a device falling edge
    p_move_on_fall_r4: assert property (@(posedge clk) disable iff (rst)
        past_ok && state_q == ST_SHIFT && $past(state_q) == ST_SHIFT && !$past(clk_fall)
        |-> $stable(ps2_dat_oe));

    // R9: a request arriving mid-transfer does not restart the block
    p_busy_ignores_r9: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(state_q) == ST_SHIFT && $past(tx_valid) && !$past(done_d)
        |-> !tx_ready);

endmodule

// File: tb/ps2_host_tx_tb.sv
`timescale 1ns/1ps
module ps2_host_tx_tb;
    localparam int CPU    = 2;
    localparam int REQ_US = 250;
    localparam int END_US = 60;
    localparam int TO_US  = 100;
    localparam int REQ    = REQ_US * CPU;
    localparam int ENDC   = END_US * CPU;
    localparam int TO     = TO_US * CPU;
    localparam int H      = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tx_valid = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic tx_ready, done, err, ps2_clk_oe, ps2_dat_oe;
    logic dev_clk = 1'b1;
    logic dev_dat = 1'b1;
    logic clk_line, dat_line;
    int checks = 0;
    int errors = 0;
    bit model_busy = 1'b0;

    assign clk_line = dev_clk & ~ps2_clk_oe;
    assign dat_line = dev_dat & ~ps2_dat_oe;

    always #4 clk = ~clk;

    ps2_host_tx #(.CLKS_PER_US(CPU), .REQ_US(REQ_US), .END_US(END_US),
                  .TIMEOUT_US(TO_US), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst(rst), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .done(done), .err(err),
        .ps2_clk_in(clk_line), .ps2_dat_in(dat_line),
        .ps2_clk_oe(ps2_clk_oe), .ps2_dat_oe(ps2_dat_oe));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Per-cycle reference: busy from acceptance to the done cycle, quiet when idle.
    always @(negedge clk) begin
        if (!rst) begin
            if (done) model_busy = 1'b0;
            check(tx_ready == !model_busy, "R2 ready", int'(tx_ready), int'(!model_busy));
            if (!model_busy)
                check(!ps2_clk_oe && !ps2_dat_oe, "R1 idle lines",
                      int'({ps2_clk_oe, ps2_dat_oe}), 0);
            if (err) check(done, "R6 err only with done", int'(done), 1);
        end
    end

    task automatic run_xfer(input logic [7:0] d, input bit ack, input bit clock_it, input bit poke);
        int hi;
        int n;
        bit early;
        bit start_ok;
        bit close_dat;
        logic [9:0] got;
        early = 0; start_ok = 0; close_dat = 0; hi = 0;
        @(negedge clk);
        tx_valid = 1'b1;
        tx_data  = d;
        @(posedge clk);
        #1 model_busy = 1'b1;
        @(negedge clk);
        if (poke) tx_data = ~d; else tx_valid = 1'b0;
        while (ps2_clk_oe && hi < REQ + 10) begin
            hi++;
            if (hi <= REQ && ps2_dat_oe) early = 1;
            if (hi == REQ + 1) start_ok = ps2_dat_oe;
            if (poke && hi == 5) check(!tx_ready, "R9 ready low while busy", int'(tx_ready), 0);
            @(negedge clk);
        end
        tx_valid = 1'b0;
        check(hi == REQ + 1, "R2 request hold length", hi, REQ + 1);
        check(!early, "R3 data idle early in hold", int'(early), 0);
        check(start_ok, "R3 start bit in last hold cycle", int'(start_ok), 1);
        check(ps2_dat_oe, "R3 start bit at release", int'(ps2_dat_oe), 1);
        if (!clock_it) begin
            n = 0;
            while (!done && n < TO + 50) begin n++; @(negedge clk); end
            check(n == TO, "R8 timeout length", n, TO);
            check(err, "R8 timeout error", int'(err), 1);
            check(!ps2_clk_oe && !ps2_dat_oe, "R8 lines released", int'({ps2_clk_oe, ps2_dat_oe}), 0);
            return;
        end
        repeat (30) @(negedge clk);
        for (int k = 0; k < 10; k++) begin
            dev_clk = 1'b0;
            repeat (H) @(negedge clk);
            got[k] = dat_line;
            dev_clk = 1'b1;
            repeat (H) @(negedge clk);
        end
        check(got[7:0] == d, "R4 data bits lsb first", int'(got[7:0]), int'(d));
        check(got[8] == ~(^d), "R5 odd parity", int'(got[8]), int'(~(^d)));
        check(got[9] == 1'b1, "R5 stop released", int'(got[9]), 1);
        if (ack) dev_dat = 1'b0;
        repeat (4) @(negedge clk);
        dev_clk = 1'b0;
        n = 0;
        while (!ps2_clk_oe && n < 50) begin n++; @(negedge clk); end
        hi = 0;
        while (ps2_clk_oe && hi < ENDC + 10) begin
            hi++;
            if (ps2_dat_oe) close_dat = 1;
            @(negedge clk);
        end
        check(hi == ENDC, "R7 closing hold length", hi, ENDC);
        check(!close_dat, "R7 data released in close", int'(close_dat), 0);
        check(done, "R7 done at clock release", int'(done), 1);
        check(err == !ack, "R6 acknowledge result", int'(err), int'(!ack));
        dev_clk = 1'b1;
        dev_dat = 1'b1;
        @(negedge clk);
        check(!done && tx_ready, "R1 idle after done", int'({done, tx_ready}), 1);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(tx_ready && !done && !err && !ps2_clk_oe && !ps2_dat_oe, "R1 reset state",
              int'({tx_ready, done, err, ps2_clk_oe, ps2_dat_oe}), 16);
        run_xfer(8'hA5, 1'b1, 1'b1, 1'b0);
        run_xfer(8'h00, 1'b1, 1'b1, 1'b0);
        run_xfer(8'hFF, 1'b1, 1'b1, 1'b0);
        run_xfer(8'h01, 1'b1, 1'b1, 1'b0);
        run_xfer(8'h3C, 1'b0, 1'b1, 1'b0);   // R6 missing acknowledge
        run_xfer(8'h81, 1'b1, 1'b1, 1'b1);   // R9 request offered while busy
        run_xfer(8'h96, 1'b1, 1'b0, 1'b0);   // R8 device never clocks
        repeat (3) @(negedge clk);
        run_xfer(8'h5A, 1'b1, 1'b1, 1'b0);
        repeat (5) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule